// File: doc/BRIEF.md
# Display Sync Timing Generator

This block produces the horizontal sync, vertical sync and data enable strobes for a parallel RGB panel. It also produces the pixel column and row of the active picture. A line and a frame are each made of five consecutive phases: a short lead-in gap before sync, the sync pulse, the back porch, the active region and the front porch. The length of each phase comes from a configuration input. The horizontal counter advances once per clock. The vertical counter advances once for every completed line.

Configuration arrives as five 32-bit words, each holding a horizontal/vertical pair. Four words give the phase lengths and one gives the active width and height. Software normally programs the lead-in gap as 1 on both axes and takes that cycle out of the front porch, so the overall period matches the panel. The configuration words must be held stable while the generator runs. New values are applied by pulsing reset.

Top module: `disp_sync_gen`

## Requirements
- R1: While reset is low, and on the first clock after it is released, hsync_n and vsync_n are 1, de is 0, and px_x and px_y are 0. Counting starts from the first cycle of the lead-in gap of line 0.
- R2: Every configuration word carries the horizontal value in bits 15:0 and the vertical value in bits 31:16. In cfg_active, the width is in bits 15:0 and the height in bits 31:16.
- R3: Each line runs lead-in (cfg_lead), sync (cfg_sync), back porch (cfg_bp), active (width) and front porch (cfg_fp) for exactly the programmed number of clocks. hsync_n is 0 exactly during the sync phase.
- R4: The vertical counter steps once per completed line, through the same five phases measured in lines. vsync_n is 0 for every clock of the vertical sync lines, and it changes only at a line boundary.
- R5: de is 1 exactly when both axes are in their active phase (active-high). Sync is never asserted while de is 1.
- R6: While de is 1, px_x counts from 0 at the first active pixel of a line and px_y counts from 0 at the first active line. Both are 0 whenever de is 0.
- R7: A phase length programmed as 0 behaves as a length of 1.
- R8: An active width above MAX_W (default 1366) is treated as MAX_W, and an active height above MAX_H (default 768) is treated as MAX_H.
- R9: After the last front-porch clock of the last front-porch line, the next clock begins the lead-in gap of line 0. The frame period is the sum of all horizontal lengths times the sum of all vertical lengths.
- R10: All outputs are registered. An output shows the counter position of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_lead | input | 32 | Lead-in gap before sync: H in 15:0, V in 31:16 |
| cfg_sync | input | 32 | Sync width pair |
| cfg_bp | input | 32 | Back porch pair |
| cfg_fp | input | 32 | Front porch pair |
| cfg_active | input | 32 | Width in 15:0, height in 31:16 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active high |
| px_x | output | $clog2(MAX_W) | Column within the active region |
| px_y | output | $clog2(MAX_H) | Row within the active region |

## Verification
The assertions check the following on every cycle: data enable and sync never overlap, the coordinates are zero outside the active region, the column advances by one and the row holds steady within an active run, the coordinates stay below the size limits, and the vertical sync edges fall only on line boundaries. Only the bench scenarios can show the exact phase lengths, the bit positions of the configuration fields, zero-length handling, clamping, the frame period and the reset state. The bench shows these by comparing every output on every clock against a position model for several configurations.

// File: rtl/disp_sync_pkg.sv
// Shared types and helpers for the display sync timing generator.
// Assumes configuration fields are 16 bits wide on each axis.
package disp_sync_pkg;

    localparam int FIELD_W = 16;

    typedef enum logic [2:0] {
        PH_LEAD = 3'd0,
        PH_SYNC = 3'd1,
        PH_BP   = 3'd2,
        PH_ACT  = 3'd3,
        PH_FP   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] lead;
        logic [FIELD_W-1:0] sync;
        logic [FIELD_W-1:0] bp;
        logic [FIELD_W-1:0] act;
        logic [FIELD_W-1:0] fp;
    } axis_len_t;

    // Raise a zero length to one so every phase lasts at least a clock.
    function automatic logic [FIELD_W-1:0] fn_min1(input logic [FIELD_W-1:0] v);
        return (v == '0) ? FIELD_W'(1) : v;
    endfunction

    // Limit a value to an upper bound.
    function automatic logic [FIELD_W-1:0] fn_clamp(input logic [FIELD_W-1:0] v,
                                                    input logic [FIELD_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/disp_cfg_unpack.sv
// Splits the packed horizontal/vertical configuration words into one
// length set per axis. Applies the one-clock minimum and the size limit.
// Assumes the words are static while the generator runs.
module disp_cfg_unpack
    import disp_sync_pkg::*;
#(
    parameter int MAX_W = 1366,
    parameter int MAX_H = 768
) (
    input  logic [31:0]         cfg_lead,
    input  logic [31:0]         cfg_sync,
    input  logic [31:0]         cfg_bp,
    input  logic [31:0]         cfg_fp,
    input  logic [31:0]         cfg_active,
    output axis_len_t [1:0]     lens_o
);

    // Axis 0 is horizontal (low half), axis 1 is vertical (high half).
    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam int LIM = (a == 0) ? MAX_W : MAX_H;
        always_comb begin
            lens_o[a].lead = fn_min1(cfg_lead[a*FIELD_W +: FIELD_W]);
            lens_o[a].sync = fn_min1(cfg_sync[a*FIELD_W +: FIELD_W]);
            lens_o[a].bp   = fn_min1(cfg_bp[a*FIELD_W +: FIELD_W]);
            lens_o[a].fp   = fn_min1(cfg_fp[a*FIELD_W +: FIELD_W]);
            lens_o[a].act  = fn_min1(fn_clamp(cfg_active[a*FIELD_W +: FIELD_W],
                                              FIELD_W'(LIM)));
        end
    end

endmodule

// File: rtl/disp_axis_ctr.sv
// One timing axis: walks lead-in, sync, back porch, active and front porch,
// holding each phase for its programmed length. It advances only when step
// is high. wrap_o flags the step that leaves the last front-porch count.
// Assumes every length is at least one.
module disp_axis_ctr
    import disp_sync_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  axis_len_t           len,
    output phase_e              phase_o,
    output logic [FIELD_W-1:0]  count_o,
    output logic                wrap_o
);

    logic [FIELD_W-1:0] cur_len;
    logic               last;

    // Select the length of the phase in progress.
    always_comb begin
        case (phase_o)
            PH_LEAD: cur_len = len.lead;
            PH_SYNC: cur_len = len.sync;
            PH_BP:   cur_len = len.bp;
            PH_ACT:  cur_len = len.act;
            default: cur_len = len.fp;
        endcase
    end

    assign last   = (count_o == cur_len - 1'b1);
    assign wrap_o = step && last && (phase_o == PH_FP);

    // Advance the count, moving to the next phase at its last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= PH_LEAD;
            count_o <= '0;
        end else if (step) begin
            if (last) begin
                count_o <= '0;
                case (phase_o)
                    PH_LEAD: phase_o <= PH_SYNC;
                    PH_SYNC: phase_o <= PH_BP;
                    PH_BP:   phase_o <= PH_ACT;
                    PH_ACT:  phase_o <= PH_FP;
                    default: phase_o <= PH_LEAD;
                endcase
            end else begin
                count_o <= count_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/disp_out_stage.sv
// Output register stage: turns both axis positions into active-low syncs,
// active-high data enable and the active-region coordinates.
// Assumes the active lengths never exceed the coordinate range.
module disp_out_stage
    import disp_sync_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              h_phase,
    input  phase_e              v_phase,
    input  logic [FIELD_W-1:0]  h_count,
    input  logic [FIELD_W-1:0]  v_count,
    output logic                hsync_n,
    output logic                vsync_n,
    output logic                de,
    output logic [XW-1:0]       px_x,
    output logic [YW-1:0]       px_y
);

    logic in_act;

    // Active region; the range guard keeps coordinates inside their width.
    assign in_act = (h_phase == PH_ACT) && (v_phase == PH_ACT) &&
                    (h_count < FIELD_W'(2**XW)) && (v_count < FIELD_W'(2**YW));

    // Register all panel-facing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            de      <= 1'b0;
            px_x    <= '0;
            px_y    <= '0;
        end else begin
            hsync_n <= (h_phase != PH_SYNC);
            vsync_n <= (v_phase != PH_SYNC);
            de      <= in_act;
            px_x    <= in_act ? h_count[XW-1:0] : '0;
            px_y    <= in_act ? v_count[YW-1:0] : '0;
        end
    end

endmodule

// File: rtl/disp_sync_gen.sv
// Top of the display sync timing generator. It unpacks the configuration,
// runs a horizontal counter every clock and a vertical counter once per line,
// then registers the panel outputs.
// Assumes the configuration is stable between resets.
module disp_sync_gen
    import disp_sync_pkg::*;
#(
    parameter int MAX_W = 1366,
    parameter int MAX_H = 768
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [31:0]                 cfg_lead,
    input  logic [31:0]                 cfg_sync,
    input  logic [31:0]                 cfg_bp,
    input  logic [31:0]                 cfg_fp,
    input  logic [31:0]                 cfg_active,
    output logic                        hsync_n,
    output logic                        vsync_n,
    output logic                        de,
    output logic [$clog2(MAX_W)-1:0]    px_x,
    output logic [$clog2(MAX_H)-1:0]    px_y
);

    localparam int XW = $clog2(MAX_W);
    localparam int YW = $clog2(MAX_H);

    axis_len_t [1:0]    lens;
    phase_e             h_phase, v_phase;
    logic [FIELD_W-1:0] h_count, v_count;
    logic               h_wrap, v_wrap_unused;

    disp_cfg_unpack #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_unpack (
        .cfg_lead   (cfg_lead),
        .cfg_sync   (cfg_sync),
        .cfg_bp     (cfg_bp),
        .cfg_fp     (cfg_fp),
        .cfg_active (cfg_active),
        .lens_o     (lens)
    );

    disp_axis_ctr u_hctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (1'b1),
        .len     (lens[0]),
        .phase_o (h_phase),
        .count_o (h_count),
        .wrap_o  (h_wrap)
    );

    disp_axis_ctr u_vctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (h_wrap),
        .len     (lens[1]),
        .phase_o (v_phase),
        .count_o (v_count),
        .wrap_o  (v_wrap_unused)
    );

    disp_out_stage #(.XW(XW), .YW(YW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_phase (h_phase),
        .v_phase (v_phase),
        .h_count (h_count),
        .v_count (v_count),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .de      (de),
        .px_x    (px_x),
        .px_y    (px_y)
    );

endmodule

// File: rtl/disp_sync_gen_chk.sv
// Cycle-by-cycle checker for the display sync timing generator.
// It watches the ports only and is bound to the top module below.
module disp_sync_gen_chk #(
    parameter int MAX_W = 1366,
    parameter int MAX_H = 768
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        hsync_n,
    input logic                        vsync_n,
    input logic                        de,
    input logic [$clog2(MAX_W)-1:0]    px_x,
    input logic [$clog2(MAX_H)-1:0]    px_y
);

    // R5: no sync pulse during active data.
    p_de_no_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));

    // R6: coordinates rest at zero outside the active region.
    p_coords_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (px_x == '0 && px_y == '0));

    // R6: column steps by one within an active run.
    p_x_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(de) && de) |-> (px_x == $past(px_x) + 1'b1));

    // R6: row holds within an active run.
    p_y_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(de) && de) |-> (px_y == $past(px_y)));

    // R8: coordinates stay below the size limits.
    p_coord_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (int'(px_x) < MAX_W && int'(px_y) < MAX_H));

    // R4: vertical sync edges occur only at a line start.
    p_vedge_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vsync_n) || $fell(vsync_n)) |-> (hsync_n && !de));

endmodule

bind disp_sync_gen disp_sync_gen_chk #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .de      (de),
    .px_x    (px_x),
    .px_y    (px_y)
);

// File: tb/sim_disp_sync_gen.sv
`timescale 1ns/1ps
// Directed bench: each scenario programs a configuration, resets the block
// and compares every output on every clock against a position model.
module sim_disp_sync_gen;

    localparam int MAX_W = 1366;
    localparam int MAX_H = 768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_lead = '0, cfg_sync = '0, cfg_bp = '0, cfg_fp = '0, cfg_active = '0;
    logic        hsync_n, vsync_n, de;
    logic [$clog2(MAX_W)-1:0] px_x;
    logic [$clog2(MAX_H)-1:0] px_y;

    int n_checks = 0;
    int n_fails  = 0;
    int hl [5];
    int vl [5];

    always #4 clk = ~clk;

    disp_sync_gen #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_lead(cfg_lead), .cfg_sync(cfg_sync), .cfg_bp(cfg_bp),
        .cfg_fp(cfg_fp), .cfg_active(cfg_active),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .px_x(px_x), .px_y(px_y)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Model lengths: zero becomes one (R7), active clamped to the limit (R8).
    function automatic int eff(input int v, input int lim);
        int r = (v > lim) ? lim : v;
        return (r == 0) ? 1 : r;
    endfunction

    // Program raw lengths in order lead, sync, bp, active, fp; pack per R2.
    task automatic apply_cfg(input int hr[5], input int vr[5]);
        cfg_lead   = {vr[0][15:0], hr[0][15:0]};
        cfg_sync   = {vr[1][15:0], hr[1][15:0]};
        cfg_bp     = {vr[2][15:0], hr[2][15:0]};
        cfg_active = {vr[3][15:0], hr[3][15:0]};
        cfg_fp     = {vr[4][15:0], hr[4][15:0]};
        for (int i = 0; i < 5; i++) begin
            hl[i] = eff(hr[i], (i == 3) ? MAX_W : 65535);
            vl[i] = eff(vr[i], (i == 3) ? MAX_H : 65535);
        end
    endtask

    function automatic int tot(input int l[5]);
        return l[0] + l[1] + l[2] + l[3] + l[4];
    endfunction

    // Phase index (0..4) and offset within it for a position on one axis.
    function automatic void locate(input int p, input int l[5], output int ph, output int off);
        int base = 0;
        ph = 4; off = 0;
        for (int i = 0; i < 5; i++) begin
            if (p < base + l[i]) begin
                ph = i; off = p - base;
                return;
            end
            base += l[i];
        end
    endfunction

    // Reset, check the reset state (R1), then compare n clocks (R10 latency).
    task automatic run_cfg(input string tag, input int n);
        int hph, hoff, vph, voff, ln;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({tag, " R1"}, "hsync_n", hsync_n, 1);
        chk({tag, " R1"}, "vsync_n", vsync_n, 1);
        chk({tag, " R1"}, "de", de, 0);
        chk({tag, " R1"}, "px_x", px_x, 0);
        chk({tag, " R1"}, "px_y", px_y, 0);
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            // After the (i+1)-th clock the outputs show position i (R10).
            ln = i / tot(hl);
            locate(i % tot(hl), hl, hph, hoff);
            locate(ln % tot(vl), vl, vph, voff);
            chk({tag, " R3"}, "hsync_n", hsync_n, (hph == 1) ? 0 : 1);
            chk({tag, " R4"}, "vsync_n", vsync_n, (vph == 1) ? 0 : 1);
            chk({tag, " R5"}, "de", de, (hph == 3 && vph == 3) ? 1 : 0);
            chk({tag, " R6"}, "px_x", px_x, (hph == 3 && vph == 3) ? hoff : 0);
            chk({tag, " R6"}, "px_y", px_y, (hph == 3 && vph == 3) ? voff : 0);
        end
    endtask

    // R1 R3 R4 R9: basic timing over two whole frames plus a few clocks.
    task automatic t_basic();
        apply_cfg('{1, 2, 3, 8, 2}, '{1, 1, 2, 4, 1});
        run_cfg("basic R9", 2 * tot(hl) * tot(vl) + 5);
    endtask

    // R2: distinct halves expose any swap of the horizontal and vertical fields.
    task automatic t_packing();
        apply_cfg('{1, 3, 1, 5, 4}, '{2, 2, 1, 3, 3});
        run_cfg("packing R2", 2 * tot(hl) * tot(vl) + 3);
    endtask

    // R7: zero-length phases last one clock (or one line).
    task automatic t_zero();
        apply_cfg('{0, 0, 2, 0, 0}, '{0, 0, 0, 2, 0});
        run_cfg("zero R7", 2 * tot(hl) * tot(vl) + 3);
    endtask

    // R8: oversized width is limited to MAX_W.
    task automatic t_clamp_w();
        apply_cfg('{1, 2, 2, 2000, 2}, '{1, 1, 1, 1, 1});
        run_cfg("clampw R8", tot(hl) * tot(vl) + tot(hl));
    endtask

    // R8: oversized height is limited to MAX_H.
    task automatic t_clamp_h();
        apply_cfg('{1, 1, 1, 1, 1}, '{1, 1, 1, 900, 1});
        run_cfg("clamph R8", tot(hl) * tot(vl) + 2 * tot(hl));
    endtask

    initial begin
        t_basic();
        t_packing();
        t_zero();
        t_clamp_w();
        t_clamp_h();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule